// File: doc/BRIEF.md
# Multiprocessor-Format Asynchronous Serial Transmitter

This block serialises bytes onto a single output line. Every frame has a low start bit, then seven or eight data bits sent least significant bit first, then one multiprocessor bit, then one or two high stop bits. Between frames the line rests high. Software fills a one-byte holding buffer and then clears a buffer-empty flag. The hardware moves the buffer into its shift register on a bit boundary and sets the flag again, so software can refill the buffer while the current frame is still on the line.

The transmitter looks at the buffer-empty flag at the start of the stop-bit period. If new data is waiting, the next start bit follows the last stop bit with no gap. If the buffer is still empty, the block sets a transmit-end flag and leaves the line high. Both flags drive interrupt request levels, each gated by its own enable. Bit timing comes from a programmable 16-bit divider.

Software uses a small write-only register set. Address 0 is the buffer. Address 1 is control. Address 2 is the flag handshake. Addresses 3 and 4 hold the low and high bytes of the divider.

Top module: `mpx_uart_tx`

## Requirements
- R1: A frame begins with exactly one bit time of low level on `txd`.
- R2: Control bit 3 selects the data length: 1 sends bits 6..0 (seven bits), 0 sends bits 7..0 (eight bits). The byte written to address 0 is sent least significant bit first.
- R3: The bit after the data carries control bit 5, sampled when the frame starts.
- R4: Control bit 4 selects the number of high stop bits: 1 gives two, 0 gives one.
- R5: A write to address 2 with data bit 0 at 0 clears the buffer-empty flag and the transmit-end flag. When the buffer is moved to the shift register, the buffer-empty flag returns to 1, and it is already 1 within the first bit time of the frame.
- R6: `txi_req` equals the buffer-empty flag ANDed with control bit 1.
- R7: If the buffer-empty flag is 0 when the multiprocessor bit ends, the next frame's start bit directly follows the last stop bit.
- R8: If the buffer-empty flag is 1 when the multiprocessor bit ends, the transmit-end flag becomes 1, and after the stop bits `txd` stays high.
- R9: `tei_req` equals the transmit-end flag ANDed with control bit 2.
- R10: Every bit, including each stop bit, lasts exactly DIV+1 clock cycles. DIV is the 16-bit divider value written as a low byte at address 3 and a high byte at address 4.
- R11: While control bit 0 (transmit enable) is 0, `txd` is high and both flags are 1. Clearing the enable abandons any frame in progress, and the abandoned data is not sent once the block is enabled again.
- R12: After reset, `txd` is high, both flags are 1 and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial output line |
| txi_req | output | 1 | Transmit-data-empty interrupt request level |
| tei_req | output | 1 | Transmit-end interrupt request level |
| buf_empty | output | 1 | Buffer-empty flag |
| tx_end | output | 1 | Transmit-end flag |

## Verification
A wrong bit counter or a wrong data-length decode shifts every later field of the frame. That shows up on `txd` within one frame, at the mid-bit sample of the multiprocessor or stop position. A wrong divider count stretches or shrinks the low run of an all-zero frame, and the error grows with every bit, so a measurement of ten bit times exposes it. A handshake flag left in the wrong state shows up in one of two ways: as a gap, or a missing gap, between chained frames, or as a wrong `txi_req` or `tei_req` level as soon as the next boundary at the multiprocessor bit is reached.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_BUF  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIVL = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIVH = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_MPB, ST_STOP1, ST_STOP2
  } tx_state_e;

  // bit 0 enable, 1 tie, 2 teie, 3 len7, 4 two_stop, 5 mpb
  typedef struct packed {
    logic mpb;
    logic two_stop;
    logic len7;
    logic teie;
    logic tie;
    logic tx_en;
  } ctrl_t;

  function automatic logic [2:0] last_data_idx(input logic len7);
    return len7 ? 3'd6 : 3'd7;
  endfunction

  function automatic int unsigned frame_bits(input logic len7, input logic two_stop);
    return 2 + (len7 ? 7 : 8) + (two_stop ? 2 : 1);
  endfunction

endpackage

// File: rtl/mpx_tx_regs.sv
module mpx_tx_regs
  import mpx_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                load_evt,
  input  logic                end_evt,
  output ctrl_t               ctrl,
  output logic [DATA_W-1:0]   buf_q,
  output logic [DIV_W-1:0]    div_q,
  output logic                buf_empty,
  output logic                tx_end
);

  localparam int unsigned HI_W = DIV_W - 8;

  logic clr_evt;
  assign clr_evt = wr_en && (wr_addr == A_FLAG) && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      buf_q <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_BUF:  buf_q <= wr_data;
        A_CTRL: ctrl  <= ctrl_t'(wr_data[5:0]);
        A_DIVL: div_q[7:0] <= wr_data;
        A_DIVH: div_q[DIV_W-1:8] <= wr_data[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_empty <= 1'b1;
      tx_end    <= 1'b1;
    end else if (!ctrl.tx_en) begin
      buf_empty <= 1'b1;
      tx_end    <= 1'b1;
    end else begin
      if (load_evt)     buf_empty <= 1'b1;
      else if (clr_evt) buf_empty <= 1'b0;
      if (clr_evt)      tx_end <= 1'b0;
      else if (end_evt) tx_end <= 1'b1;
    end
  end

  p_load_sets_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && ctrl.tx_en) |=> buf_empty);

  p_disabled_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.tx_en |=> (buf_empty && tx_end));

endmodule

// File: rtl/mpx_tx_baud.sv
module mpx_tx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/mpx_tx_shifter.sv
module mpx_tx_shifter
  import mpx_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  ctrl_t             cfg,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] buf_q,
  output logic              txd,
  output logic              load_evt,
  output logic              end_evt
);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [2:0]        bit_idx;
  logic              len7_q, two_q, mpb_q, chain_q;
  logic              tx_en, line, last_stop;

  assign tx_en     = cfg.tx_en;
  assign load_evt  = tx_en && tick && !buf_empty &&
                     ((state == ST_IDLE) || (state == ST_MPB));
  assign end_evt   = tx_en && tick && buf_empty && (state == ST_MPB);
  assign last_stop = (state == ST_STOP2) || ((state == ST_STOP1) && !two_q);

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_MPB:   line = mpb_q;
      default:  line = 1'b1;
    endcase
  end

  assign txd = tx_en ? line : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      len7_q  <= 1'b0;
      two_q   <= 1'b0;
      mpb_q   <= 1'b0;
      chain_q <= 1'b0;
    end else if (!tx_en) begin
      state   <= ST_IDLE;
      chain_q <= 1'b0;
    end else begin
      if (load_evt) shreg <= buf_q;
      if (tick) begin
        case (state)
          ST_IDLE: if (!buf_empty) begin
            state  <= ST_START;
            len7_q <= cfg.len7;
            two_q  <= cfg.two_stop;
            mpb_q  <= cfg.mpb;
          end
          ST_START: begin
            state   <= ST_DATA;
            bit_idx <= '0;
          end
          ST_DATA: begin
            if (bit_idx == last_data_idx(len7_q)) begin
              state <= ST_MPB;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= shreg >> 1;
            end
          end
          ST_MPB: begin
            state   <= ST_STOP1;
            chain_q <= !buf_empty;
          end
          default: begin
            if (state == ST_STOP1 && two_q) begin
              state <= ST_STOP2;
            end else if (chain_q) begin
              state   <= ST_START;
              chain_q <= 1'b0;
              len7_q  <= cfg.len7;
              two_q   <= cfg.two_stop;
              mpb_q   <= cfg.mpb;
            end else begin
              state <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && state == ST_IDLE) |=> (!tx_en || !txd));

  p_chain_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tick && last_stop && chain_q) |=> (!tx_en || !txd));

  p_end_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!tx_en || txd));

  p_bit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tick) |=> (!tx_en || $stable(txd)));

endmodule

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx
  import mpx_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                txd,
  output logic                txi_req,
  output logic                tei_req,
  output logic                buf_empty,
  output logic                tx_end
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] buf_q;
  logic [DIV_W-1:0]  div_q;
  logic              tick, load_evt, end_evt;

  mpx_tx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_evt(load_evt), .end_evt(end_evt),
    .ctrl(ctrl), .buf_q(buf_q), .div_q(div_q),
    .buf_empty(buf_empty), .tx_end(tx_end)
  );

  mpx_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(ctrl.tx_en), .div(div_q), .tick(tick)
  );

  mpx_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(ctrl),
    .buf_empty(buf_empty), .buf_q(buf_q), .txd(txd),
    .load_evt(load_evt), .end_evt(end_evt)
  );

  assign txi_req = buf_empty && ctrl.tie;
  assign tei_req = tx_end && ctrl.teie;

  p_end_after_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> buf_empty);

endmodule

// File: tb/mpx_uart_tx_bench.sv
module mpx_uart_tx_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       txd, txi_req, tei_req, buf_empty, tx_end;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpx_uart_tx u_mpx_uart_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .txd(txd), .txi_req(txi_req), .tei_req(tei_req),
    .buf_empty(buf_empty), .tx_end(tx_end)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int v);
    wr(3'd3, v[7:0]);
    wr(3'd4, v[15:8]);
  endtask

  function automatic int flen(input logic l7, input logic two);
    return 1 + (l7 ? 7 : 8) + 1 + (two ? 2 : 1);
  endfunction

  function automatic logic [31:0] exp_frame(input logic [7:0] d, input logic l7,
                                            input logic two, input logic mp);
    logic [31:0] f;
    int nd;
    f = '1;
    nd = l7 ? 7 : 8;
    f[0] = 1'b0;
    for (int k = 0; k < nd; k++) f[1+k] = d[k];
    f[1+nd] = mp;
    return f & ((32'h1 << flen(l7, two)) - 1);
  endfunction

  task automatic wait_fall();
    int guard = 0;
    while (txd !== 1'b0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 3000) chk("start bit timeout", 32'd0, 32'd1);
  endtask

  task automatic capture(input int n, input int t, output logic [31:0] cap,
                         output logic e0, output logic x0);
    cap = '0;
    wait_fall();
    repeat (t/2) @(negedge clk);
    e0 = buf_empty;
    x0 = tx_end;
    for (int k = 0; k < n; k++) begin
      cap[k] = txd;
      if (k < n-1) repeat (t) @(negedge clk);
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    wait_fall();
    while (txd === 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cap;
    logic e0, x0;
    int n;
    int guard;
    logic quiet;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 txd", {31'd0, txd}, 32'd1);
    chk("R12 buf_empty", {31'd0, buf_empty}, 32'd1);
    chk("R12 tx_end", {31'd0, tx_end}, 32'd1);
    chk("R12 txi_req", {31'd0, txi_req}, 32'd0);
    chk("R12 tei_req", {31'd0, tei_req}, 32'd0);

    // R10 bit time: an all-zero 8-bit frame with mp=0 gives ten low bit times
    set_div(3);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    measure_low(n);
    chk("R10 low run div=3", n, 32'd40);
    repeat (20) @(negedge clk);
    set_div(6);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    measure_low(n);
    chk("R10 low run div=6", n, 32'd70);
    repeat (30) @(negedge clk);
    set_div(3);

    // sweep every length / stop / mp combination over several data patterns
    for (int c = 0; c < 8; c++) begin
      logic l7, two, mp;
      l7 = c[0]; two = c[1]; mp = c[2];
      wr(3'd1, {2'b00, mp, two, l7, 3'b111});
      for (int di = 0; di < 4; di++) begin
        logic [7:0] d;
        case (di)
          0: d = 8'h00;
          1: d = 8'hFF;
          2: d = 8'hA5;
          default: d = 8'h3C ^ 8'(c);
        endcase
        chk("R6 txi with empty buffer", {31'd0, txi_req}, 32'd1);
        wr(3'd0, d);
        wr(3'd2, 8'h00);
        capture(flen(l7, two), 4, cap, e0, x0);
        chk("R1 R2 R3 R4 frame", cap, exp_frame(d, l7, two, mp));
        chk("R5 empty set by load", {31'd0, e0}, 32'd1);
        chk("R5 end cleared by handshake", {31'd0, x0}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R8 tx_end after frame", {31'd0, tx_end}, 32'd1);
        chk("R8 mark level", {31'd0, txd}, 32'd1);
        chk("R9 tei with enable", {31'd0, tei_req}, 32'd1);
      end
    end

    // R6 / R9 masking by the enables
    wr(3'd1, 8'h01);
    chk("R6 txi masked", {31'd0, txi_req}, 32'd0);
    chk("R9 tei masked", {31'd0, tei_req}, 32'd0);

    // R7 back-to-back chaining
    wr(3'd1, 8'h37);
    fork
      capture(24, 4, cap, e0, x0);
      begin
        wr(3'd0, 8'h5A);
        wr(3'd2, 8'h00);
        guard = 0;
        while (buf_empty !== 1'b1 && guard < 1000) begin
          @(negedge clk);
          guard++;
        end
        chk("R7 tx_end low while chaining", {31'd0, tx_end}, 32'd0);
        wr(3'd0, 8'hC3);
        wr(3'd2, 8'h00);
      end
    join
    chk("R7 chained frames", cap,
        exp_frame(8'h5A, 1'b0, 1'b1, 1'b1) | (exp_frame(8'hC3, 1'b0, 1'b1, 1'b1) << 12));
    repeat (4) @(negedge clk);
    chk("R8 tx_end after chain", {31'd0, tx_end}, 32'd1);

    // R11 abandon a frame by clearing enable
    wr(3'd1, 8'h00);
    set_div(200);
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    chk("R5 handshake clears empty", {31'd0, buf_empty}, 32'd0);
    chk("R5 handshake clears end", {31'd0, tx_end}, 32'd0);
    chk("R6 txi low with full buffer", {31'd0, txi_req}, 32'd0);
    wait_fall();
    @(negedge clk);
    chk("R6 txi after load", {31'd0, txi_req}, 32'd1);
    repeat (30) @(negedge clk);
    chk("R1 start bit held", {31'd0, txd}, 32'd0);
    wr(3'd1, 8'h06);
    @(negedge clk);
    chk("R11 txd high when disabled", {31'd0, txd}, 32'd1);
    chk("R11 empty forced", {31'd0, buf_empty}, 32'd1);
    chk("R11 end forced", {31'd0, tx_end}, 32'd1);
    chk("R9 tei follows forced end", {31'd0, tei_req}, 32'd1);
    set_div(3);
    wr(3'd1, 8'h07);
    quiet = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 1'b0;
    end
    chk("R11 abandoned data not resent", {31'd0, quiet}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule